// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

The block is a watchdog that software reaches through one 32-bit control/status word on a small synchronous register port. A reference-clock prescaler, selected by a two-bit clock-select field, produces counting ticks. While the enable bit is set, a timeout counter counts those ticks. When the selected interval expires, the interrupt flag sets, and the interrupt output follows that flag gated by interrupt enable. The counter then enters a second stage of a fixed number of ticks. If reset enable is set when that stage ends, the block emits a one-cycle reset request. The same edge also returns the control word to its default value and sets a reset flag that survives the reset.

Software keeps the system alive by writing the restart bit, which clears the prescaler and the counter and returns the block to the first stage. Clearing the enable bit pauses the count without losing it. A separate system-reset input lets the chip's reset logic clear the word while it keeps the reset flag, so that boot code can learn why the system restarted. The register port has no handshake. A write takes effect at the clock edge that samples it, and read data is a combinational decode of the address. The port carries no data stream, so it has no valid/ready pair and nothing is ever held back.

Top module: `wdt_ctrl`

## Requirements
- R1: After power-on reset the control word reads 0x0000_0400 (clock select 1, every other bit 0), and `irq_o` and `rst_req_o` are 0.
- R2: The control word is decoded only at byte offset 0x1C. Any other address reads 0, and a write to any other address leaves the word unchanged. Field positions: clock select [11:10], enable 7, interrupt enable 6, interval select [5:4], interrupt flag 3, reset flag 2, reset enable 1, restart 0.
- R3: The interrupt and reset flags clear when a 1 is written to them and are unchanged when a 0 is written. The restart bit always reads 0.
- R4: With enable set, the interrupt flag sets exactly N·P clock edges after the write that restarts the count, and it is still clear one edge earlier. N = 2^(INT_EXP_BASE + 2·interval select). P = 2^PS_EXPk for clock select k.
- R5: The interrupt flag sets at timeout even when interrupt enable is 0. `irq_o` is 1 exactly when both the flag and interrupt enable are 1.
- R6: When the second stage of RST_TICKS prescaled ticks ends with reset enable at 1, `rst_req_o` pulses high for exactly one cycle whatever interrupt enable is. In that cycle the word already reads 0x0000_0404 (default plus reset flag).
- R7: With reset enable at 0, the end of the second stage produces no reset request, and the reset flag stays 0.
- R8: With enable at 0 the prescaler and the counter hold their values. Setting enable again resumes the count, so the timeout comes after only the remaining edges.
- R9: Writing restart during the second stage returns the block to the first stage with a zero count, which postpones the reset request.
- R10: A pulse on `sys_rst_i` returns the word to default on the next edge and keeps the reset flag at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low power-on reset; clears everything, including the reset flag |
| sys_rst_i | input | 1 | Synchronous system reset from the chip reset logic; keeps the reset flag |
| addr_i | input | ADDR_W | Register byte address |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt: flag AND interrupt enable |
| rst_req_o | output | 1 | One-cycle reset request to the system reset generator |

## Verification
A write is visible in the read data after the single edge that samples it. The interrupt flag and `irq_o` are due N·P edges after the restarting write, and the reset request N·P + RST_TICKS·P edges after it. After a pause, the remaining edges are counted from the resuming write. The driver notes the edge index of every write and pushes each expected value together with the exact edge index at which it is due. The monitor compares the outputs on the falling edge that follows that rising edge. For each timeout it also checks the edge just before, so an early or late result of even one cycle is reported.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned CTRL_OFFSET = 32'h1C;

  localparam int BIT_RESTART  = 0;
  localparam int BIT_RST_EN   = 1;
  localparam int BIT_RST_FLAG = 2;
  localparam int BIT_INT_FLAG = 3;
  localparam int BIT_ISEL_LO  = 4;
  localparam int BIT_INT_EN   = 6;
  localparam int BIT_ENABLE   = 7;
  localparam int BIT_CSEL_LO  = 10;

  localparam logic [1:0] CSEL_DEFAULT = 2'd1;

  typedef struct packed {
    logic [1:0] csel;
    logic       enable;
    logic       int_en;
    logic [1:0] isel;
    logic       int_flag;
    logic       rst_flag;
    logic       rst_en;
  } ctrl_t;

  typedef enum logic {
    STAGE_INT = 1'b0,
    STAGE_RST = 1'b1
  } stage_t;

  function automatic ctrl_t ctrl_default(input logic keep_rst_flag);
    ctrl_t c;
    c          = '0;
    c.csel     = CSEL_DEFAULT;
    c.rst_flag = keep_rst_flag;
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[BIT_CSEL_LO +: 2] = c.csel;
    w[BIT_ENABLE]       = c.enable;
    w[BIT_INT_EN]       = c.int_en;
    w[BIT_ISEL_LO +: 2] = c.isel;
    w[BIT_INT_FLAG]     = c.int_flag;
    w[BIT_RST_FLAG]     = c.rst_flag;
    w[BIT_RST_EN]       = c.rst_en;
    return w;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PS_EXP0 = 0,
  parameter int PS_EXP1 = 8,
  parameter int PS_EXP2 = 11,
  parameter int PS_EXP3 = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       run,
  input  logic [1:0] csel,
  output logic       tick
);

  localparam int EXPS [4] = '{PS_EXP0, PS_EXP1, PS_EXP2, PS_EXP3};

  function automatic int max_exp();
    int m;
    m = 0;
    for (int i = 0; i < 4; i++) begin
      if (EXPS[i] > m) m = EXPS[i];
    end
    return m;
  endfunction

  localparam int PS_MAX = max_exp();
  localparam int PW     = (PS_MAX > 0) ? PS_MAX : 1;

  logic [PW-1:0] div_q;
  logic [PW-1:0] div_lim;

  // last count value of the selected ratio; ratio 1 gives 0, so every cycle ticks
  always_comb begin
    div_lim = PW'((64'd1 << EXPS[csel]) - 64'd1);
  end

  assign tick = run && (div_q == div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (clr) begin
      div_q <= '0;
    end else if (run) begin
      if (tick) div_q <= '0;
      else      div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout
  import wdt_pkg::*;
#(
  parameter int INT_EXP_BASE = 14,
  parameter int RST_TICKS    = 1024,
  localparam int IW          = INT_EXP_BASE + 7,
  localparam int RW          = $clog2(RST_TICKS) + 1,
  localparam int CW          = (IW > RW) ? IW : RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [1:0]    isel,
  input  logic          rst_en,
  output logic          int_hit,
  output logic          rst_fire,
  output logic [CW-1:0] count,
  output stage_t        stage
);

  localparam logic [CW-1:0] RST_LAST = CW'(RST_TICKS - 1);

  logic [CW-1:0] int_last;
  logic          at_int_end;
  logic          at_rst_end;

  always_comb begin
    int_last = CW'((64'd1 << (INT_EXP_BASE + 2 * int'(isel))) - 64'd1);
  end

  assign at_int_end = (stage == STAGE_INT) && (count == int_last);
  assign at_rst_end = (stage == STAGE_RST) && (count == RST_LAST);

  // a restart in the same cycle suppresses both events
  assign int_hit  = tick && !clr && at_int_end;
  assign rst_fire = tick && !clr && at_rst_end && rst_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      stage <= STAGE_INT;
    end else if (clr || rst_fire) begin
      count <= '0;
      stage <= STAGE_INT;
    end else if (tick) begin
      if (at_int_end) begin
        count <= '0;
        stage <= STAGE_RST;
      end else if (!at_rst_end) begin
        count <= count + 1'b1;
      end
      // at the end of the reset stage without reset enable: park at the limit
    end
  end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sys_rst,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        int_hit,
  input  logic        rst_fire,
  output ctrl_t       ctrl,
  output logic        restart
);

  assign restart = wr_sel && wr_data[BIT_RESTART];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= ctrl_default(1'b0);
    end else if (sys_rst || rst_fire) begin
      ctrl <= ctrl_default(ctrl.rst_flag || rst_fire);
    end else begin
      if (wr_sel) begin
        ctrl.csel     <= wr_data[BIT_CSEL_LO +: 2];
        ctrl.enable   <= wr_data[BIT_ENABLE];
        ctrl.int_en   <= wr_data[BIT_INT_EN];
        ctrl.isel     <= wr_data[BIT_ISEL_LO +: 2];
        ctrl.rst_en   <= wr_data[BIT_RST_EN];
        ctrl.rst_flag <= ctrl.rst_flag && !wr_data[BIT_RST_FLAG];
        ctrl.int_flag <= ctrl.int_flag && !wr_data[BIT_INT_FLAG];
      end
      // setting the flag outranks a clear in the same cycle
      if (int_hit) ctrl.int_flag <= 1'b1;
    end
  end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int INT_EXP_BASE = 14,
  parameter int RST_TICKS    = 1024,
  parameter int PS_EXP0      = 0,
  parameter int PS_EXP1      = 8,
  parameter int PS_EXP2      = 11,
  parameter int PS_EXP3      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_rst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o,
  output logic              rst_req_o
);

  localparam int IW    = INT_EXP_BASE + 7;
  localparam int RW    = $clog2(RST_TICKS) + 1;
  localparam int CNT_W = (IW > RW) ? IW : RW;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFFSET);

  ctrl_t             ctrl;
  logic [31:0]       ctrl_word;
  logic              addr_hit;
  logic              wr_sel;
  logic              restart;
  logic              tick;
  logic              int_hit;
  logic              rst_fire;
  logic [CNT_W-1:0]  tmo_count;
  stage_t            tmo_stage;
  logic              rst_req_q;

  assign addr_hit = (addr_i == CTRL_ADDR);
  assign wr_sel   = wr_en_i && addr_hit;

  wdt_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_rst  (sys_rst_i),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data_i),
    .int_hit  (int_hit),
    .rst_fire (rst_fire),
    .ctrl     (ctrl),
    .restart  (restart)
  );

  wdt_prescaler #(
    .PS_EXP0 (PS_EXP0),
    .PS_EXP1 (PS_EXP1),
    .PS_EXP2 (PS_EXP2),
    .PS_EXP3 (PS_EXP3)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart || sys_rst_i || rst_fire),
    .run   (ctrl.enable),
    .csel  (ctrl.csel),
    .tick  (tick)
  );

  wdt_timeout #(
    .INT_EXP_BASE (INT_EXP_BASE),
    .RST_TICKS    (RST_TICKS)
  ) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (restart || sys_rst_i),
    .tick     (tick),
    .isel     (ctrl.isel),
    .rst_en   (ctrl.rst_en),
    .int_hit  (int_hit),
    .rst_fire (rst_fire),
    .count    (tmo_count),
    .stage    (tmo_stage)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= rst_fire;
  end

  assign ctrl_word = ctrl_pack(ctrl);
  assign rd_data_o = addr_hit ? ctrl_word : 32'd0;
  assign irq_o     = ctrl.int_flag && ctrl.int_en;
  assign rst_req_o = rst_req_q;

endmodule

// File: rtl/wdt_ctrl_chk.sv
module wdt_ctrl_chk
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_rst_i,
  input logic             wr_sel,
  input logic [31:0]      wr_data_i,
  input logic [31:0]      ctrl_word,
  input logic [CNT_W-1:0] tmo_count,
  input stage_t           tmo_stage,
  input logic             rst_req_o
);

  logic restart_wr;
  assign restart_wr = wr_sel && wr_data_i[BIT_RESTART];

  assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  assert_req_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> ctrl_word == 32'h0000_0404);

  assert_req_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(ctrl_word[BIT_RST_EN]));

  assert_paused_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_word[BIT_ENABLE] && !restart_wr && !sys_rst_i) |=> $stable(tmo_count));

  assert_restart_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_wr |=> (tmo_count == '0) && (tmo_stage == STAGE_INT));

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word[BIT_INT_FLAG] && !(wr_sel && wr_data_i[BIT_INT_FLAG]) && !sys_rst_i)
      |=> (ctrl_word[BIT_INT_FLAG] || rst_req_o));

  assert_sysrst_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_i |=> ((ctrl_word & ~32'h4) == 32'h0000_0400)
                  && (ctrl_word[BIT_RST_FLAG] == $past(ctrl_word[BIT_RST_FLAG])));

endmodule

bind wdt_ctrl wdt_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sys_rst_i (sys_rst_i),
  .wr_sel    (wr_sel),
  .wr_data_i (wr_data_i),
  .ctrl_word (ctrl_word),
  .tmo_count (tmo_count),
  .tmo_stage (tmo_stage),
  .rst_req_o (rst_req_o)
);

// File: tb/sim_wdt_ctrl.sv
`timescale 1ns/1ps
module sim_wdt_ctrl;

  localparam int BASE  = 4;
  localparam int RTK   = 16;
  localparam int PE [4] = '{0, 2, 3, 4};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_rst_i = 1'b0;
  logic [7:0]  addr_i = 8'h1C;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;
  logic        rst_req_o;

  always #4 clk = ~clk;   // 125 MHz

  wdt_ctrl #(
    .ADDR_W(8), .INT_EXP_BASE(BASE), .RST_TICKS(RTK),
    .PS_EXP0(PE[0]), .PS_EXP1(PE[1]), .PS_EXP2(PE[2]), .PS_EXP3(PE[3])
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sys_rst_i(sys_rst_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  int unsigned cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int unsigned due;
    logic [31:0] mask;
    logic [31:0] rd;
    logic        irq;
    logic        req;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int unsigned nticks(input int is, input int cs);
    return (32'd1 << (BASE + 2 * is)) * (32'd1 << PE[cs]);
  endfunction

  function automatic int unsigned rticks(input int cs);
    return RTK * (32'd1 << PE[cs]);
  endfunction

  task automatic expect_at(input int unsigned due, input logic [31:0] mask,
                           input logic [31:0] rd, input logic irq, input logic req,
                           input string tag);
    exp_t e;
    e.due = due; e.mask = mask; e.rd = rd; e.irq = irq; e.req = req; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares the outputs at the falling edge after the due rising edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      if (e.due < cyc) chk({e.tag, " missed"}, cyc, e.due);
      else begin
        chk({e.tag, " rd"},  rd_data_o & e.mask, e.rd & e.mask);
        chk({e.tag, " irq"}, {31'd0, irq_o}, {31'd0, e.irq});
        chk({e.tag, " req"}, {31'd0, rst_req_o}, {31'd0, e.req});
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] v, output int unsigned e);
    @(posedge clk); #1;
    addr_i = a; wr_en_i = 1'b1; wr_data_i = v;
    @(posedge clk); #1;
    wr_en_i = 1'b0; wr_data_i = '0; addr_i = 8'h1C;
    e = cyc;
  endtask

  task automatic wait_until(input int unsigned c);
    while (cyc < c) @(posedge clk);
  endtask

  task automatic drain();
    wait (sb.size() == 0);
    @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned e0, e1, e2, t, r, used;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 word", rd_data_o, 32'h400);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 req", {31'd0, rst_req_o}, 32'd0);

    // R2 other offsets read zero, writes there ignored
    @(posedge clk); #1 addr_i = 8'h18;
    #1 chk("R2 other read", rd_data_o, 32'd0);
    addr_i = 8'h1C;
    wr(8'h18, 32'hFFFF_FFFF, e0);
    expect_at(e0 + 1, 32'hFFFF_FFFF, 32'h400, 0, 0, "R2 ignored write");
    drain();

    // R3 flags and restart read back 0
    wr(8'h1C, 32'h40D, e0);
    expect_at(e0 + 1, 32'hFFFF_FFFF, 32'h400, 0, 0, "R3 w1c and restart");
    drain();

    // R4 sweep of all prescalers and intervals
    for (int cs = 0; cs < 4; cs++) begin
      for (int is = 0; is < 4; is++) begin
        t = nticks(is, cs);
        wr(8'h1C, (cs << 10) | (is << 4) | 32'hC9, e0);
        expect_at(e0 + t - 1, 32'h8, 32'h0, 0, 0, "R4 before timeout");
        expect_at(e0 + t,     32'h8, 32'h8, 1, 0, "R4 at timeout");
        drain();
      end
    end

    // R5 flag without interrupt enable, then enable gates irq
    t = nticks(0, 0); r = rticks(0);
    wr(8'h1C, 32'h89, e0);
    expect_at(e0 + t, 32'hFFFF_FFFF, 32'h088, 0, 0, "R5 flag ie=0");
    drain();
    wr(8'h1C, 32'hC0, e0);
    expect_at(e0 + 1, 32'hFFFF_FFFF, 32'h0C8, 1, 0, "R5 irq follows ie");
    drain();

    // R6 reset request with interrupt enable set
    wr(8'h1C, 32'hCF, e0);
    expect_at(e0 + t,         32'hFFFF_FFFF, 32'h0CA, 1, 0, "R6 flag ie=1");
    expect_at(e0 + t + r - 1, 32'hFFFF_FFFF, 32'h0CA, 1, 0, "R6 no early req");
    expect_at(e0 + t + r,     32'hFFFF_FFFF, 32'h404, 0, 1, "R6 req pulse");
    expect_at(e0 + t + r + 1, 32'hFFFF_FFFF, 32'h404, 0, 0, "R6 req single");
    drain();
    // R6 again with interrupt enable clear
    wr(8'h1C, 32'h8F, e0);
    expect_at(e0 + 1,     32'hFFFF_FFFF, 32'h082, 0, 0, "R3 rflag cleared");
    expect_at(e0 + t,     32'hFFFF_FFFF, 32'h08A, 0, 0, "R6 flag ie=0");
    expect_at(e0 + t + r, 32'hFFFF_FFFF, 32'h404, 0, 1, "R6 req ie=0");
    drain();

    // R10 system reset keeps reset flag
    wr(8'h1C, 32'hC42, e0);
    expect_at(e0 + 1, 32'hFFFF_FFFF, 32'hC46, 0, 0, "R10 setup");
    drain();
    @(posedge clk); #1 sys_rst_i = 1'b1;
    @(posedge clk); #1 sys_rst_i = 1'b0;
    e0 = cyc;
    expect_at(e0, 32'hFFFF_FFFF, 32'h404, 0, 0, "R10 default keep rflag");
    drain();
    wr(8'h1C, 32'h404, e0);
    expect_at(e0 + 1, 32'hFFFF_FFFF, 32'h400, 0, 0, "R3 rflag w1c");
    drain();

    // R7 no reset without reset enable
    wr(8'h1C, 32'hCD, e0);
    expect_at(e0 + t + r,     32'hFFFF_FFFF, 32'h0C8, 1, 0, "R7 no req");
    expect_at(e0 + t + r + 5, 32'hFFFF_FFFF, 32'h0C8, 1, 0, "R7 rflag clear");
    drain();

    // R8 pause and resume with prescale 4
    t = nticks(0, 1);
    wr(8'h1C, 32'h4C9, e0);
    expect_at(e0 + 1, 32'hFFFF_FFFF, 32'h4C0, 0, 0, "R8 running");
    wait_until(e0 + 30);
    wr(8'h1C, 32'h440, e1);
    used = e1 - e0;
    expect_at(e1 + 1,   32'hFFFF_FFFF, 32'h440, 0, 0, "R8 paused");
    expect_at(e1 + 150, 32'hFFFF_FFFF, 32'h440, 0, 0, "R8 still paused");
    drain();
    wr(8'h1C, 32'h4C0, e2);
    expect_at(e2 + (t - used) - 1, 32'h8, 32'h0, 0, 0, "R8 before remaining");
    expect_at(e2 + (t - used),     32'h8, 32'h8, 1, 0, "R8 after remaining");
    drain();

    // R9 restart in the reset stage postpones the request
    t = nticks(0, 0);
    wr(8'h1C, 32'h8F, e0);
    expect_at(e0 + t, 32'hFFFF_FFFF, 32'h08A, 0, 0, "R9 entered reset stage");
    wait_until(e0 + 20);
    wr(8'h1C, 32'h8B, e1);
    expect_at(e0 + t + r, 32'hFFFF_FFFF, 32'h082, 0, 0, "R9 no req at old time");
    expect_at(e1 + t,     32'hFFFF_FFFF, 32'h08A, 0, 0, "R9 new timeout");
    expect_at(e1 + t + r, 32'hFFFF_FFFF, 32'h404, 0, 1, "R9 req after restart");
    drain();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule